// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block is the receive half of a codec-side serial audio link. A controller sends fixed 256-bit frames on one data line, framed by a SYNC strobe. The transmitter changes its bits on the rising edge of the bit clock, and this block samples on the falling edge. The first bit after SYNC rises starts a frame. The frame is a 16-bit tag slot followed by twelve 20-bit data slots, each sent most significant bit first.

The block rebuilds the frame into parallel words and decodes the tag into three results:
- a frame-valid flag,
- one valid flag per data slot,
- a two-bit codec identifier.

All results are published together, once per frame, with a one-cycle done strobe. The block also checks the framing. It pulses an error output when the SYNC pulse has the wrong width, or when a new frame starts before the current one has finished.

Downstream logic takes the slot words on the done strobe and uses only the slots whose valid flag is set.

Top module: `audio_frame_rx`

## Requirements
- R1: `sdata_i` and `sync_i` are sampled on the falling edge of `bit_clk_i`. The first sample at which `sync_i` is seen high after being low is bit 15 of the tag.
- R2: After the 16 tag bits come twelve 20-bit slots, each MSB first. Slot k (1..12) appears on `slot_data_o[(k-1)*20 +: 20]`.
- R3: `frame_valid_o` equals received tag bit 15. `slot_valid_o[k-1]` equals tag bit (15-k) AND tag bit 15, so all slot flags are low when tag bit 15 is 0.
- R4: `codec_id_o` equals tag bits 1:0 (00 = primary, any other value = secondary). Tag bit 2 has no effect on any output.
- R5: All outputs change together on the falling edge that samples the last bit of slot 12. `frame_done_o` is high for exactly that one cycle, and all outputs hold their values otherwise.
- R6: If `sync_i` is high for any number of samples other than 16, `frame_err_o` pulses for one cycle at the sample where `sync_i` falls. The frame is still received and completes with `frame_done_o`.
- R7: A SYNC rise before 256 bits of the current frame have been sampled pulses `frame_err_o` for one cycle. The partial frame is dropped without `frame_done_o`, and reception restarts at the new rise.
- R8: Frames sent back to back, with the next SYNC rise on the sample right after slot 12 ends, are each received with no error.
- R9: Data on `sdata_i` while no frame is in progress and `sync_i` stays low has no effect on the outputs.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock; inputs are sampled on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame strobe, high during the tag slot |
| sdata_i | input | 1 | Serial frame data, MSB first |
| slot_data_o | output | 240 | Twelve 20-bit slot words; slot k at bits (k-1)*20 +: 20 |
| slot_valid_o | output | 12 | Per-slot valid flags, gated by frame valid |
| frame_valid_o | output | 1 | Tag bit 15 of the last completed frame |
| codec_id_o | output | 2 | Tag bits 1:0 of the last completed frame |
| frame_done_o | output | 1 | One-cycle strobe when a frame's outputs update |
| frame_err_o | output | 1 | One-cycle strobe on a framing error |

## Verification
The bench drives slot words that differ in every slot, so a receiver that is off by one bit or swaps slots returns wrong words. A tag with the frame-valid bit clear but every slot bit set catches a decode that forgets the gating. A tag with the reserved bit and a secondary codec ID set catches tag-field decode errors. SYNC widths of 15 and 17, a frame cut off at bit 100 by a new rise, and two frames with no gap between them exercise the framing logic: a receiver that mis-measures SYNC, flags a correct back-to-back start, or publishes a truncated frame will show the wrong error or done count, or the wrong slot words.

// File: rtl/afrx_pkg.sv
`timescale 1ns/1ps
package afrx_pkg;
  localparam int unsigned TAG_W_DEF   = 16;
  localparam int unsigned SLOT_W_DEF  = 20;
  localparam int unsigned N_SLOTS_DEF = 12;
  localparam int unsigned CID_W       = 2;
  typedef logic [CID_W-1:0] cid_t;
endpackage

// File: rtl/afrx_sync_track.sv
`timescale 1ns/1ps
module afrx_sync_track #(
  parameter int unsigned TAG_W   = afrx_pkg::TAG_W_DEF,
  parameter int unsigned SLOT_W  = afrx_pkg::SLOT_W_DEF,
  parameter int unsigned N_SLOTS = afrx_pkg::N_SLOTS_DEF,
  parameter int unsigned IDX_W   = $clog2(N_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             last_o,
  output logic             frame_end_o,
  output logic             sync_rise_o,
  output logic             active_o,
  output logic             err_o
);
  localparam int unsigned MAX_W = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
  localparam int unsigned BIT_W = $clog2(MAX_W);
  localparam int unsigned HI_W  = $clog2(TAG_W + 2);
  localparam logic [BIT_W-1:0] TAG_LAST  = BIT_W'(TAG_W - 1);
  localparam logic [BIT_W-1:0] SLOT_LAST = BIT_W'(SLOT_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_SLOTS);
  localparam logic [HI_W-1:0]  HI_OK     = HI_W'(TAG_W);
  localparam logic [HI_W-1:0]  HI_MAX    = {HI_W{1'b1}};

  logic             sync_q, active_q, err_q;
  logic [IDX_W-1:0] slot_q, cur_slot;
  logic [BIT_W-1:0] bis_q, cur_bis;
  logic [HI_W-1:0]  hi_q;
  logic             rise, fall, hit, last, fend;

  always_comb begin
    rise     = sync_i & ~sync_q;
    fall     = ~sync_i & sync_q;
    hit      = rise | active_q;
    cur_slot = rise ? '0 : slot_q;
    cur_bis  = rise ? '0 : bis_q;
    last     = hit & ((cur_slot == '0) ? (cur_bis == TAG_LAST) : (cur_bis == SLOT_LAST));
    fend     = last & (cur_slot == IDX_LAST);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      slot_q   <= '0;
      bis_q    <= '0;
      hi_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      sync_q   <= sync_i;
      active_q <= hit & ~fend;
      if (hit) begin
        if (last) begin
          bis_q  <= '0;
          slot_q <= cur_slot + 1'b1;
        end else begin
          bis_q  <= cur_bis + 1'b1;
          slot_q <= cur_slot;
        end
      end
      if (rise)                       hi_q <= HI_W'(1);
      else if (sync_i && hi_q != HI_MAX) hi_q <= hi_q + 1'b1;
      // wrong strobe width, or restart inside a running frame
      err_q <= (fall && (hi_q != HI_OK)) || (rise && active_q);
    end
  end

  assign hit_o       = hit;
  assign slot_o      = cur_slot;
  assign last_o      = last;
  assign frame_end_o = fend;
  assign sync_rise_o = rise;
  assign active_o    = active_q;
  assign err_o       = err_q;
endmodule

// File: rtl/afrx_deser.sv
`timescale 1ns/1ps
module afrx_deser #(
  parameter int unsigned TAG_W   = afrx_pkg::TAG_W_DEF,
  parameter int unsigned SLOT_W  = afrx_pkg::SLOT_W_DEF,
  parameter int unsigned N_SLOTS = afrx_pkg::N_SLOTS_DEF,
  parameter int unsigned IDX_W   = $clog2(N_SLOTS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sdata_i,
  input  logic                      hit_i,
  input  logic [IDX_W-1:0]          slot_i,
  input  logic                      last_i,
  input  logic                      frame_end_i,
  output logic [TAG_W-1:0]          tag_o,
  output logic [N_SLOTS*SLOT_W-1:0] slot_data_o,
  output logic                      done_o
);
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] word_next;
  logic [TAG_W-1:0]  tag_q, tag_out_q;
  logic              done_q;

  assign word_next = {sh_q, sdata_i};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      tag_q     <= '0;
      tag_out_q <= '0;
      done_q    <= 1'b0;
    end else begin
      if (hit_i) sh_q <= word_next[SLOT_W-2:0];
      if (hit_i && last_i && slot_i == '0) tag_q <= word_next[TAG_W-1:0];
      if (frame_end_i) tag_out_q <= tag_q;
      done_q <= frame_end_i;
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic [SLOT_W-1:0] out_q;
    if (g < N_SLOTS - 1) begin : g_held
      // earlier slots wait in a holding word until the frame closes
      logic [SLOT_W-1:0] hold_q;
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q <= '0;
          out_q  <= '0;
        end else begin
          if (hit_i && last_i && slot_i == IDX_W'(g + 1)) hold_q <= word_next;
          if (frame_end_i) out_q <= hold_q;
        end
      end
    end else begin : g_final
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          out_q <= '0;
        else if (frame_end_i) out_q <= word_next;
      end
    end
    assign slot_data_o[g*SLOT_W +: SLOT_W] = out_q;
  end

  assign tag_o  = tag_out_q;
  assign done_o = done_q;
endmodule

// File: rtl/afrx_tag_decode.sv
`timescale 1ns/1ps
module afrx_tag_decode #(
  parameter int unsigned TAG_W   = afrx_pkg::TAG_W_DEF,
  parameter int unsigned N_SLOTS = afrx_pkg::N_SLOTS_DEF
) (
  input  logic [TAG_W-1:0]   tag_i,
  output logic               frame_valid_o,
  output logic [N_SLOTS-1:0] slot_valid_o,
  output afrx_pkg::cid_t     codec_id_o
);
  localparam int unsigned RSV_W = TAG_W - 1 - N_SLOTS - afrx_pkg::CID_W;

  assign frame_valid_o = tag_i[TAG_W-1];
  assign codec_id_o    = tag_i[afrx_pkg::CID_W-1:0];

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_vld
    assign slot_valid_o[k] = tag_i[TAG_W-2-k] & tag_i[TAG_W-1];
  end

  if (RSV_W > 0) begin : g_rsv
    logic unused_rsv;
    assign unused_rsv = ^tag_i[afrx_pkg::CID_W +: RSV_W];
  end
endmodule

// File: rtl/audio_frame_rx.sv
`timescale 1ns/1ps
module audio_frame_rx #(
  parameter int unsigned TAG_W   = afrx_pkg::TAG_W_DEF,
  parameter int unsigned SLOT_W  = afrx_pkg::SLOT_W_DEF,
  parameter int unsigned N_SLOTS = afrx_pkg::N_SLOTS_DEF
) (
  input  logic                      bit_clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_i,
  input  logic                      sdata_i,
  output logic [N_SLOTS*SLOT_W-1:0] slot_data_o,
  output logic [N_SLOTS-1:0]        slot_valid_o,
  output logic                      frame_valid_o,
  output logic [1:0]                codec_id_o,
  output logic                      frame_done_o,
  output logic                      frame_err_o
);
  localparam int unsigned IDX_W = $clog2(N_SLOTS + 1);

  logic             hit_w, last_w, fend_w, sync_rise_w, active_w;
  logic [IDX_W-1:0] slot_w;
  logic [TAG_W-1:0] tag_w;

  afrx_sync_track #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_track (
    .clk_i       (bit_clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .hit_o       (hit_w),
    .slot_o      (slot_w),
    .last_o      (last_w),
    .frame_end_o (fend_w),
    .sync_rise_o (sync_rise_w),
    .active_o    (active_w),
    .err_o       (frame_err_o)
  );

  afrx_deser #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_deser (
    .clk_i       (bit_clk_i),
    .rst_ni      (rst_ni),
    .sdata_i     (sdata_i),
    .hit_i       (hit_w),
    .slot_i      (slot_w),
    .last_i      (last_w),
    .frame_end_i (fend_w),
    .tag_o       (tag_w),
    .slot_data_o (slot_data_o),
    .done_o      (frame_done_o)
  );

  afrx_tag_decode #(.TAG_W(TAG_W), .N_SLOTS(N_SLOTS)) u_dec (
    .tag_i         (tag_w),
    .frame_valid_o (frame_valid_o),
    .slot_valid_o  (slot_valid_o),
    .codec_id_o    (codec_id_o)
  );
endmodule

// File: rtl/afrx_checker.sv
`timescale 1ns/1ps
module afrx_checker #(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned N_SLOTS = 12
) (
  input logic                      bit_clk_i,
  input logic                      rst_ni,
  input logic [N_SLOTS*SLOT_W-1:0] slot_data_o,
  input logic [N_SLOTS-1:0]        slot_valid_o,
  input logic                      frame_valid_o,
  input logic                      frame_done_o,
  input logic                      frame_err_o,
  input logic                      sync_rise_w,
  input logic                      active_w
);
  AST_DONE_SINGLE: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R5
  AST_DATA_HOLD: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !frame_done_o |-> $stable(slot_data_o)); // R5
  AST_VALID_HOLD: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !frame_done_o |-> $stable(slot_valid_o)); // R5
  AST_DONE_CLOSES: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    frame_done_o |-> !active_w); // R5
  AST_VALID_GATED: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> (slot_valid_o == '0)); // R3
  AST_EARLY_RISE: assert property (@(negedge bit_clk_i) disable iff (!rst_ni)
    (sync_rise_w && active_w) |=> frame_err_o); // R7
endmodule

bind audio_frame_rx afrx_checker #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_chk (
  .bit_clk_i     (bit_clk_i),
  .rst_ni        (rst_ni),
  .slot_data_o   (slot_data_o),
  .slot_valid_o  (slot_valid_o),
  .frame_valid_o (frame_valid_o),
  .frame_done_o  (frame_done_o),
  .frame_err_o   (frame_err_o),
  .sync_rise_w   (sync_rise_w),
  .active_w      (active_w)
);

// File: tb/audio_frame_rx_test.sv
`timescale 1ns/1ps
module audio_frame_rx_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync = 1'b0;
  logic         sd = 1'b0;
  logic [239:0] slot_data;
  logic [11:0]  slot_valid;
  logic         fvalid, done, err;
  logic [1:0]   cid;

  int checks = 0, failures = 0;
  int done_cnt = 0, err_cnt = 0;
  logic [239:0] cap_data = '0, prev_data = '0;

  always #5 clk = ~clk;

  audio_frame_rx uut (
    .bit_clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sdata_i(sd),
    .slot_data_o(slot_data), .slot_valid_o(slot_valid), .frame_valid_o(fvalid),
    .codec_id_o(cid), .frame_done_o(done), .frame_err_o(err)
  );

  // outputs move on the falling edge; observe 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        prev_data = cap_data;
        cap_data  = slot_data;
      end
      if (err) err_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [239:0] got, input logic [239:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [239:0] mk_words(input int seed);
    logic [239:0] w;
    for (int k = 0; k < 12; k++)
      w[k*20 +: 20] = {4'(k + 1), 16'(seed * 16'h3D1 ^ (k * 16'h1111) ^ 16'hA5C3)};
    return w;
  endfunction

  function automatic logic [255:0] mk_frame(input logic [15:0] tag, input logic [239:0] w);
    logic [255:0] f;
    f[255:240] = tag;
    for (int k = 0; k < 12; k++) f[239 - 20*k -: 20] = w[k*20 +: 20];
    return f;
  endfunction

  task automatic send(input logic [255:0] f, input int sync_len, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #2;
      sync = (i < sync_len);
      sd   = f[255 - i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      sync = 1'b0;
      sd   = i[0] ^ i[2];
    end
  endtask

  task automatic t_reset;
    chk("R10", "slot_data", slot_data, '0);
    chk("R10", "flags", {228'd0, slot_valid, fvalid, cid, done, err}, '0);
  endtask

  task automatic t_full;
    logic [239:0] w = mk_words(1);
    int d0, e0;
    idle(40);
    chk("R9", "done before frame", 240'(done_cnt), 240'd0);
    chk("R9", "data before frame", slot_data, '0);
    d0 = done_cnt; e0 = err_cnt;
    send(mk_frame(16'hFFF8, w), 16, 256);
    idle(3);
    chk("R5", "done pulses", 240'(done_cnt - d0), 240'd1);
    chk("R2", "slot words", slot_data, w);
    chk("R1", "captured at done", cap_data, w);
    chk("R3", "valid all", {227'd0, fvalid, slot_valid}, {227'd0, 1'b1, 12'hFFF});
    chk("R4", "codec primary", 240'(cid), 240'd0);
    chk("R6", "no error", 240'(err_cnt - e0), 240'd0);
  endtask

  task automatic t_partial;
    logic [239:0] w = mk_words(2);
    send(mk_frame(16'hD00E, w), 16, 256);
    idle(3);
    chk("R3", "sparse valid", {227'd0, fvalid, slot_valid}, {227'd0, 1'b1, 12'h805});
    chk("R4", "codec secondary, bit2 ignored", 240'(cid), 240'd2);
    chk("R2", "slot words", slot_data, w);
  endtask

  task automatic t_gated;
    logic [239:0] w = mk_words(3);
    send(mk_frame(16'h7FF9, w), 16, 256);
    idle(3);
    chk("R3", "gated valid", {227'd0, fvalid, slot_valid}, '0);
    chk("R4", "codec id", 240'(cid), 240'd1);
    chk("R2", "slot words", slot_data, w);
  endtask

  task automatic t_back2back;
    logic [239:0] wa = mk_words(4), wb = mk_words(5);
    int d0 = done_cnt, e0 = err_cnt;
    send(mk_frame(16'hFFF8, wa), 16, 256);
    send(mk_frame(16'hFFF8, wb), 16, 256);
    idle(3);
    chk("R8", "done pulses", 240'(done_cnt - d0), 240'd2);
    chk("R8", "first frame", prev_data, wa);
    chk("R8", "second frame", cap_data, wb);
    chk("R8", "no error", 240'(err_cnt - e0), 240'd0);
  endtask

  task automatic t_sync_width(input int len);
    logic [239:0] w = mk_words(10 + len);
    int d0 = done_cnt, e0 = err_cnt;
    send(mk_frame(16'hFFF8, w), len, 256);
    idle(3);
    chk("R6", $sformatf("error sync=%0d", len), 240'(err_cnt - e0), 240'd1);
    chk("R6", $sformatf("done sync=%0d", len), 240'(done_cnt - d0), 240'd1);
    chk("R6", $sformatf("data sync=%0d", len), slot_data, w);
  endtask

  task automatic t_early;
    logic [239:0] wa = mk_words(6), wb = mk_words(7);
    int d0 = done_cnt, e0 = err_cnt;
    send(mk_frame(16'hFFF8, wa), 16, 100);
    send(mk_frame(16'hFFF8, wb), 16, 256);
    idle(3);
    chk("R7", "error", 240'(err_cnt - e0), 240'd1);
    chk("R7", "one done", 240'(done_cnt - d0), 240'd1);
    chk("R7", "restarted frame", slot_data, wb);
  endtask

  task automatic t_hold;
    logic [239:0] keep = slot_data;
    int d0 = done_cnt;
    idle(60);
    chk("R9", "no done while idle", 240'(done_cnt - d0), 240'd0);
    chk("R5", "held data", slot_data, keep);
    chk("R5", "done low", 240'(done), 240'd0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(posedge clk); #2;
    rst_n = 1'b1;
    t_full;
    t_partial;
    t_gated;
    t_back2back;
    t_sync_width(15);
    t_sync_width(17);
    t_early;
    t_hold;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule